// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides, each clock, whether the core enters an exception, and if so which one. It watches four request lines (fast interrupt, interrupt, software interrupt, undefined instruction) together with the current program counter and the current status word. An accepted entry produces, one cycle later, everything the core needs to switch context: the target mode, the return address for the link register, the vector address for the program counter, the status word to keep as the saved copy, the updated status word with its masks raised, and a wake pulse for a halted core.

The two interrupt lines are maskable by bits of the status word. The software and undefined requests are not maskable. When several requests are accepted in one cycle, exactly one entry is taken, chosen by a fixed priority. After each entry the block applies a fixed refill charge: for a configurable number of cycles it accepts nothing, which gives the prefetch stage time to restart at the vector.

Top module: `exc_entry_seq`

## Requirements
- R1: A fast-interrupt request is not accepted while bit 6 (F mask) of `psr_in` is 1.
- R2: An interrupt request is not accepted while bit 7 (I mask) of `psr_in` is 1. Software and undefined requests are accepted regardless of either mask.
- R3: When more than one request is acceptable in the same cycle, only one entry is taken. The priority is fast interrupt, then interrupt, then software interrupt, then undefined.
- R4: `mode_out` gives the entered mode: 5'h11 for fast interrupt, 5'h12 for interrupt, 5'h13 for software interrupt, and 5'h1B for undefined.
- R5: `lr_out` is the sampled `pc_in` for either interrupt entry, and `pc_in` minus 4 for software or undefined entries.
- R6: `pc_out` is the vector address: 0x04 for undefined, 0x08 for software interrupt, 0x18 for interrupt, and 0x1C for fast interrupt.
- R7: `spsr_out` equals `psr_in` as it was sampled in the request cycle.
- R8: `psr_out` is the sampled `psr_in` with bits [4:0] replaced by the new mode and bit 7 set. Bit 6 is also set on fast-interrupt entry. All other bits are kept.
- R9: `wake` pulses together with `taken` only for fast-interrupt and interrupt entries. It stays 0 for software and undefined entries.
- R10: A request sampled at a rising edge yields `taken` high for exactly the following cycle, with all entry outputs updated at that same edge. Outside entries, the entry outputs hold their values.
- R11: For `REFILL` cycles after an entry, all requests are ignored. A request present on the next sampling edge after that window is accepted.
- R12: After reset, `taken` and `wake` are 0 and every entry output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fiq_req | input | 1 | Fast interrupt request |
| irq_req | input | 1 | Interrupt request |
| swi_req | input | 1 | Software interrupt request |
| und_req | input | 1 | Undefined instruction request |
| pc_in | input | XLEN | Current program counter |
| psr_in | input | XLEN | Current status word |
| taken | output | 1 | One-cycle entry pulse, used to flush prefetch |
| wake | output | 1 | Clears the core's halted state |
| mode_out | output | 5 | Entered mode code |
| lr_out | output | XLEN | Return address for the link register |
| pc_out | output | XLEN | Vector address |
| spsr_out | output | XLEN | Status word to save |
| psr_out | output | XLEN | Updated status word |

## Verification
The case hardest to reach is a pile-up. In it, several requests arrive while the refill window is still counting down, and the mask bits change between cycles. An entry must be refused, and the refusal must not reorder the priority once the window closes. The stimulus holds requests active across whole windows, toggles the F and I bits cycle by cycle, and raises all four lines at once. A per-cycle reference model then confirms which entry wins, and on which edge.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN     = 32,
  parameter int REFILL   = 2,
  parameter logic [XLEN-1:0] UND_VEC = 'h04,
  parameter logic [XLEN-1:0] SWI_VEC = 'h08,
  parameter logic [XLEN-1:0] IRQ_VEC = 'h18,
  parameter logic [XLEN-1:0] FIQ_VEC = 'h1C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fiq_req,
  input  logic            irq_req,
  input  logic            swi_req,
  input  logic            und_req,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] psr_in,
  output logic            taken,
  output logic            wake,
  output logic [4:0]      mode_out,
  output logic [XLEN-1:0] lr_out,
  output logic [XLEN-1:0] pc_out,
  output logic [XLEN-1:0] spsr_out,
  output logic [XLEN-1:0] psr_out
);
  localparam int CW = (REFILL < 1) ? 1 : $clog2(REFILL + 1);
  localparam logic [4:0] M_FIQ = 5'h11;
  localparam logic [4:0] M_IRQ = 5'h12;
  localparam logic [4:0] M_SVC = 5'h13;
  localparam logic [4:0] M_UND = 5'h1B;
  localparam int FBIT = 6;
  localparam int IBIT = 7;

  logic [CW-1:0] hold_cnt;
  logic busy, acc_f, acc_i, acc_s, acc_u, acc_any;
  logic [4:0] new_mode;
  logic [XLEN-1:0] new_vec, new_lr, new_psr;

  assign busy  = hold_cnt != '0;
  assign acc_f = fiq_req & ~psr_in[FBIT] & ~busy;
  assign acc_i = irq_req & ~psr_in[IBIT] & ~busy & ~acc_f;
  assign acc_s = swi_req & ~busy & ~acc_f & ~acc_i;
  assign acc_u = und_req & ~busy & ~acc_f & ~acc_i & ~acc_s;
  assign acc_any = acc_f | acc_i | acc_s | acc_u;

  assign new_mode = acc_f ? M_FIQ : acc_i ? M_IRQ : acc_s ? M_SVC : M_UND;
  assign new_vec  = acc_f ? FIQ_VEC : acc_i ? IRQ_VEC : acc_s ? SWI_VEC : UND_VEC;
  assign new_lr   = (acc_f | acc_i) ? pc_in : pc_in - XLEN'(4);

  always_comb begin
    new_psr = psr_in;
    new_psr[4:0] = new_mode;
    new_psr[IBIT] = 1'b1;
    if (acc_f) new_psr[FBIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      taken    <= 1'b0;
      wake     <= 1'b0;
      mode_out <= '0;
      lr_out   <= '0;
      pc_out   <= '0;
      spsr_out <= '0;
      psr_out  <= '0;
    end else begin
      taken <= acc_any;
      wake  <= acc_f | acc_i;
      if (acc_any) begin
        hold_cnt <= CW'(REFILL);
        mode_out <= new_mode;
        lr_out   <= new_lr;
        pc_out   <= new_vec;
        spsr_out <= psr_in;
        psr_out  <= new_psr;
      end else if (busy) begin
        hold_cnt <= hold_cnt - 1'b1;
      end
    end
  end

  assert_fmask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && mode_out == M_FIQ) |-> !$past(psr_in[FBIT]));
  assert_imask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && mode_out == M_IRQ) |-> !$past(psr_in[IBIT]));
  assert_fiq_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && mode_out != M_FIQ) |-> !($past(fiq_req) && !$past(psr_in[FBIT])));
  assert_swi_lr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && mode_out == M_SVC) |-> lr_out == $past(pc_in) - XLEN'(4));
  assert_saved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> spsr_out == $past(psr_in));
  assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (psr_out[IBIT] && psr_out[4:0] == mode_out));
  assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (taken && (mode_out == M_FIQ || mode_out == M_IRQ)));
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> !taken);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> $stable(pc_out) || $past(!rst_n));
endmodule

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;
  localparam int REFILL = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fiq_req = 0, irq_req = 0, swi_req = 0, und_req = 0;
  logic [31:0] pc_in = '0, psr_in = '0;
  logic taken, wake;
  logic [4:0] mode_out;
  logic [31:0] lr_out, pc_out, spsr_out, psr_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string lbl = "R10";

  // reference state
  int m_hold = 0;
  bit e_taken = 0, e_wake = 0;
  logic [4:0] e_mode = '0;
  logic [31:0] e_lr = '0, e_pc = '0, e_spsr = '0, e_psr = '0;

  exc_entry_seq #(.XLEN(32), .REFILL(REFILL)) uut (
    .clk(clk), .rst_n(rst_n), .fiq_req(fiq_req), .irq_req(irq_req),
    .swi_req(swi_req), .und_req(und_req), .pc_in(pc_in), .psr_in(psr_in),
    .taken(taken), .wake(wake), .mode_out(mode_out), .lr_out(lr_out),
    .pc_out(pc_out), .spsr_out(spsr_out), .psr_out(psr_out));

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic model_edge();
    bit busy, f, i, s, u;
    busy = m_hold != 0;
    f = fiq_req && !psr_in[6] && !busy;
    i = irq_req && !psr_in[7] && !busy && !f;
    s = swi_req && !busy && !f && !i;
    u = und_req && !busy && !f && !i && !s;
    e_taken = f || i || s || u;
    e_wake = f || i;
    if (e_taken) begin
      if (f) begin e_mode = 5'h11; e_pc = 32'h1C; e_lr = pc_in; end
      else if (i) begin e_mode = 5'h12; e_pc = 32'h18; e_lr = pc_in; end
      else if (s) begin e_mode = 5'h13; e_pc = 32'h08; e_lr = pc_in - 4; end
      else begin e_mode = 5'h1B; e_pc = 32'h04; e_lr = pc_in - 4; end
      e_spsr = psr_in;
      e_psr = psr_in;
      e_psr[4:0] = e_mode;
      e_psr[7] = 1'b1;
      if (f) e_psr[6] = 1'b1;
      m_hold = REFILL;
    end else if (busy) m_hold--;
  endtask

  task automatic compare_all();
    chk({lbl, " taken"}, 32'(taken), 32'(e_taken));
    chk("R9 wake", 32'(wake), 32'(e_wake));
    chk("R4 mode", 32'(mode_out), 32'(e_mode));
    chk("R5 lr", lr_out, e_lr);
    chk("R6 pc", pc_out, e_pc);
    chk("R7 spsr", spsr_out, e_spsr);
    chk("R8 psr", psr_out, e_psr);
  endtask

  task automatic cyc(bit f, bit i, bit s, bit u, logic [31:0] pc, logic [31:0] psr, string l);
    fiq_req = f; irq_req = i; swi_req = s; und_req = u; pc_in = pc; psr_in = psr;
    lbl = l;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 32'h100, 32'h10, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    lbl = "R12";
    compare_all();
    rst_n = 1'b1;
    idle(2);
    // R1: F mask blocks fast interrupt, then clear mask
    cyc(1, 0, 0, 0, 32'h200, 32'h0000_0050, "R1");
    cyc(1, 0, 0, 0, 32'h204, 32'h0000_0010, "R1");
    idle(3);
    // R2: I mask blocks interrupt, software still goes through
    cyc(0, 1, 0, 0, 32'h300, 32'h0000_0090, "R2");
    cyc(0, 1, 1, 0, 32'h304, 32'h0000_0090, "R2");
    idle(3);
    cyc(0, 1, 0, 0, 32'h308, 32'hF000_0010, "R2");
    idle(3);
    // R3: all four together; held through the refill window (R11)
    for (int k = 0; k < 4; k++) cyc(1, 1, 1, 1, 32'h400 + 4 * k, 32'h0000_001F, "R3");
    for (int k = 0; k < 4; k++) cyc(0, 1, 1, 1, 32'h500 + 4 * k, 32'h0000_0040, "R11");
    for (int k = 0; k < 4; k++) cyc(0, 0, 1, 1, 32'h600 + 4 * k, 32'h0000_00C0, "R3");
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 32'h0000_0002 + 4 * k, 32'h0000_00D3, "R5");
    idle(3);
    // R11: a request right after entry is ignored, then accepted
    cyc(0, 0, 1, 0, 32'h700, 32'h10, "R11");
    cyc(0, 0, 0, 1, 32'h704, 32'h10, "R11");
    cyc(0, 0, 0, 1, 32'h708, 32'h10, "R11");
    cyc(0, 0, 0, 1, 32'h70C, 32'h10, "R11");
    idle(3);
    // mixed stimulus with toggling masks
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0] & r[1], r[2] & r[3], r[4] & r[5] & r[6], r[7] & r[8] & r[9],
          $urandom, {$urandom} & 32'hFFFF_FFC0 | {26'b0, r[11:10], 4'b0}, "R3");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R10 watchdog expired: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule